// File: doc/BRIEF.md
# Console Register Lamp Selector

This block feeds the operator console lamps from a bank of internal processor registers. A four-bit rotary selector code picks what the operator wants to see. The chosen register always appears on the byte lamps. When the code names either half of one of the two address register pairs, both halves of that pair also appear on the address lamps, with the first-named register in the upper byte. One further code shows a storage byte together with its storage address.

Pair and storage views are interlocked. They are shown only while the processor clock is stopped and writing is disabled. Otherwise the address lamps stay dark and the valid flag drops. A single pair register on the byte lamps stays visible in every state. Each displayed byte has a parity lamp. An end-of-execution lamp is set by a branch-on-interrupt microinstruction and cleared by the next microinstruction word. It therefore holds while the clock is stopped. Every lamp is registered, so any input change shows on the lamps after one clock edge.

Top module: `console_lamp_select`

## Requirements
- R1: Codes 0 to 11 put the addressed register on `byte_lamps` one clock edge after the code is presented. Codes 0 to 7 leave `addr_lamps` at zero and raise `disp_valid`.
- R2: Code 8 or 9, with `clk_run` low and `allow_wr` low, drives `addr_lamps` to {register 8, register 9} and raises `disp_valid`.
- R3: Code 10 or 11, under the same interlock, drives `addr_lamps` to {register 10, register 11} and raises `disp_valid`.
- R4: Codes 8 to 11, while `clk_run` or `allow_wr` is high, still show the selected register on `byte_lamps`, but `addr_lamps` is zero and `disp_valid` is low.
- R5: Code 12 with the interlock met shows `stor_data` on `byte_lamps` and `stor_addr` on `addr_lamps`, with `disp_valid` high. Without the interlock, both displays and `disp_valid` are zero.
- R6: Codes 13, 14 and 15 blank both displays and both parity lamp sets, and hold `disp_valid` low.
- R7: A parity lamp is lit exactly when its field is displayed and that field's eight bits hold an even number of ones (odd parity). A blanked field has a dark parity lamp. `addr_par[1]` covers bits 15:8 and `addr_par[0]` covers bits 7:0.
- R8: `eox_lamp` becomes 1 after an edge with `uinst_step` and `uinst_boi` both high. It becomes 0 after an edge with `uinst_step` high and `uinst_boi` low. `uinst_boi` without `uinst_step` has no effect.
- R9: While `uinst_step` is low, `eox_lamp` keeps its value.
- R10: A synchronous active-high `rst` clears every lamp output and `disp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | 4 | Rotary selector code |
| regs | input | 12 x 8 | Register bank; entries 8/9 and 10/11 form the pairs |
| stor_data | input | 8 | Storage data byte |
| stor_addr | input | 16 | Storage address |
| clk_run | input | 1 | Processor clock running |
| allow_wr | input | 1 | Writing enabled |
| uinst_step | input | 1 | A microinstruction word executed this cycle |
| uinst_boi | input | 1 | That word is a branch-on-interrupt |
| byte_lamps | output | 8 | Byte display |
| byte_par | output | 1 | Byte display parity lamp |
| addr_lamps | output | 16 | Address display |
| addr_par | output | 2 | Address display parity lamps, one per byte |
| disp_valid | output | 1 | Requested display is shown |
| eox_lamp | output | 1 | End-of-execution lamp |

## Verification
A misdecoded selector code or a wrong interlock term shows at the lamps one edge after the code is applied. It appears as a wrong byte, a lit or dark address field, or a wrong valid flag. Sweeping every code against every interlock state exposes each such case on the next cycle. A wrong end-of-execution state is visible directly on `eox_lamp`. It persists until the next microinstruction step, so the hold cycles in the sequence make it show.

// File: rtl/csl_pkg.sv
package csl_pkg;
   typedef enum logic [2:0] {
      SK_PLAIN   = 3'd0,
      SK_PAIR_IJ = 3'd1,
      SK_PAIR_UV = 3'd2,
      SK_STORE   = 3'd3,
      SK_NONE    = 3'd4
   } sel_kind_e;
endpackage

// File: rtl/csl_decode.sv
module csl_decode
   import csl_pkg::*;
#(
   parameter int SEL_W = 4,
   parameter int NREG  = 12,
   parameter int IDX_I = 8,
   parameter int IDX_J = 9,
   parameter int IDX_U = 10,
   parameter int IDX_V = 11,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [SEL_W-1:0] sel,
   output sel_kind_e        kind,
   output logic [IDX_W-1:0] idx
);
   localparam logic [SEL_W-1:0] STORE_CODE = SEL_W'(NREG);

   always_comb begin
      kind = SK_NONE;
      idx  = '0;
      if (sel < STORE_CODE) begin
         idx = IDX_W'(sel);
         if (sel == SEL_W'(IDX_I) || sel == SEL_W'(IDX_J))
            kind = SK_PAIR_IJ;
         else if (sel == SEL_W'(IDX_U) || sel == SEL_W'(IDX_V))
            kind = SK_PAIR_UV;
         else
            kind = SK_PLAIN;
      end else if (sel == STORE_CODE) begin
         kind = SK_STORE;
      end
   end
endmodule

// File: rtl/csl_route.sv
module csl_route
   import csl_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int NREG   = 12,
   parameter int IDX_I  = 8,
   parameter int IDX_J  = 9,
   parameter int IDX_U  = 10,
   parameter int IDX_V  = 11,
   localparam int IDX_W  = $clog2(NREG),
   localparam int ADDR_W = 2 * BYTE_W
) (
   input  sel_kind_e                   kind,
   input  logic [IDX_W-1:0]            idx,
   input  logic [NREG-1:0][BYTE_W-1:0] regs,
   input  logic [BYTE_W-1:0]           stor_data,
   input  logic [ADDR_W-1:0]           stor_addr,
   input  logic                        clk_run,
   input  logic                        allow_wr,
   output logic [BYTE_W-1:0]           byte_nxt,
   output logic                        byte_on,
   output logic [ADDR_W-1:0]           addr_nxt,
   output logic                        addr_on,
   output logic                        valid_nxt
);
   logic quiet;
   assign quiet = !clk_run && !allow_wr;

   always_comb begin
      byte_nxt  = '0;
      byte_on   = 1'b0;
      addr_nxt  = '0;
      addr_on   = 1'b0;
      valid_nxt = 1'b0;
      unique case (kind)
         SK_PLAIN: begin
            byte_nxt  = regs[idx];
            byte_on   = 1'b1;
            valid_nxt = 1'b1;
         end
         SK_PAIR_IJ: begin
            byte_nxt = regs[idx];
            byte_on  = 1'b1;
            if (quiet) begin
               addr_nxt  = {regs[IDX_I], regs[IDX_J]};
               addr_on   = 1'b1;
               valid_nxt = 1'b1;
            end
         end
         SK_PAIR_UV: begin
            byte_nxt = regs[idx];
            byte_on  = 1'b1;
            if (quiet) begin
               addr_nxt  = {regs[IDX_U], regs[IDX_V]};
               addr_on   = 1'b1;
               valid_nxt = 1'b1;
            end
         end
         SK_STORE: begin
            if (quiet) begin
               byte_nxt  = stor_data;
               byte_on   = 1'b1;
               addr_nxt  = stor_addr;
               addr_on   = 1'b1;
               valid_nxt = 1'b1;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/csl_parity.sv
module csl_parity #(
   parameter int W   = 8,
   parameter bit ODD = 1'b1
) (
   input  logic [W-1:0] d,
   input  logic         en,
   output logic         p
);
   generate
      if (ODD) begin : g_odd
         assign p = en & ~(^d);
      end else begin : g_even
         assign p = en & (^d);
      end
   endgenerate
endmodule

// File: rtl/csl_eox_latch.sv
module csl_eox_latch (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic boi,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= 1'b0;
      else if (step) q <= boi;
   end
endmodule

// File: rtl/console_lamp_select.sv
module console_lamp_select
   import csl_pkg::*;
#(
   parameter int SEL_W   = 4,
   parameter int BYTE_W  = 8,
   parameter int NREG    = 12,
   parameter int IDX_I   = 8,
   parameter int IDX_J   = 9,
   parameter int IDX_U   = 10,
   parameter int IDX_V   = 11,
   parameter bit PAR_ODD = 1'b1,
   localparam int ADDR_W = 2 * BYTE_W,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [SEL_W-1:0]            sel_code,
   input  logic [NREG-1:0][BYTE_W-1:0] regs,
   input  logic [BYTE_W-1:0]           stor_data,
   input  logic [ADDR_W-1:0]           stor_addr,
   input  logic                        clk_run,
   input  logic                        allow_wr,
   input  logic                        uinst_step,
   input  logic                        uinst_boi,
   output logic [BYTE_W-1:0]           byte_lamps,
   output logic                        byte_par,
   output logic [ADDR_W-1:0]           addr_lamps,
   output logic [1:0]                  addr_par,
   output logic                        disp_valid,
   output logic                        eox_lamp
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
      if (NREG + 1 > (1 << SEL_W)) begin : g_bad_sel
         $error("selector too narrow for register count plus storage code");
      end
      if (IDX_I >= NREG || IDX_J >= NREG || IDX_U >= NREG || IDX_V >= NREG) begin : g_bad_idx
         $error("pair index outside register bank");
      end
      if (IDX_I == IDX_J || IDX_U == IDX_V || IDX_I == IDX_U || IDX_I == IDX_V
          || IDX_J == IDX_U || IDX_J == IDX_V) begin : g_bad_pair
         $error("pair indices must be distinct");
      end
   endgenerate

   sel_kind_e          kind;
   logic [IDX_W-1:0]   idx;
   logic [BYTE_W-1:0]  byte_nxt;
   logic               byte_on;
   logic [ADDR_W-1:0]  addr_nxt;
   logic               addr_on;
   logic               valid_nxt;
   logic               bpar_nxt;
   logic [1:0]         apar_nxt;

   csl_decode #(
      .SEL_W(SEL_W), .NREG(NREG),
      .IDX_I(IDX_I), .IDX_J(IDX_J), .IDX_U(IDX_U), .IDX_V(IDX_V)
   ) u_dec (
      .sel(sel_code), .kind(kind), .idx(idx)
   );

   csl_route #(
      .BYTE_W(BYTE_W), .NREG(NREG),
      .IDX_I(IDX_I), .IDX_J(IDX_J), .IDX_U(IDX_U), .IDX_V(IDX_V)
   ) u_route (
      .kind(kind), .idx(idx), .regs(regs),
      .stor_data(stor_data), .stor_addr(stor_addr),
      .clk_run(clk_run), .allow_wr(allow_wr),
      .byte_nxt(byte_nxt), .byte_on(byte_on),
      .addr_nxt(addr_nxt), .addr_on(addr_on),
      .valid_nxt(valid_nxt)
   );

   csl_parity #(.W(BYTE_W), .ODD(PAR_ODD)) u_bpar (
      .d(byte_nxt), .en(byte_on), .p(bpar_nxt)
   );

   for (genvar b = 0; b < 2; b++) begin : g_apar
      csl_parity #(.W(BYTE_W), .ODD(PAR_ODD)) u_apar (
         .d(addr_nxt[b*BYTE_W +: BYTE_W]), .en(addr_on), .p(apar_nxt[b])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         byte_lamps <= '0;
         byte_par   <= 1'b0;
         addr_lamps <= '0;
         addr_par   <= '0;
         disp_valid <= 1'b0;
      end else begin
         byte_lamps <= byte_nxt;
         byte_par   <= bpar_nxt;
         addr_lamps <= addr_nxt;
         addr_par   <= apar_nxt;
         disp_valid <= valid_nxt;
      end
   end

   csl_eox_latch u_eox (
      .clk(clk), .rst(rst), .step(uinst_step), .boi(uinst_boi), .q(eox_lamp)
   );
endmodule

// File: rtl/csl_checker.sv
module csl_checker #(
   parameter int SEL_W   = 4,
   parameter int BYTE_W  = 8,
   parameter int NREG    = 12,
   parameter int IDX_I   = 8,
   parameter int IDX_J   = 9,
   parameter int IDX_U   = 10,
   parameter int IDX_V   = 11,
   localparam int ADDR_W = 2 * BYTE_W
) (
   input logic                        clk,
   input logic                        rst,
   input logic [SEL_W-1:0]            sel_code,
   input logic [NREG-1:0][BYTE_W-1:0] regs,
   input logic [BYTE_W-1:0]           stor_data,
   input logic [ADDR_W-1:0]           stor_addr,
   input logic                        clk_run,
   input logic                        allow_wr,
   input logic                        uinst_step,
   input logic                        uinst_boi,
   input logic [BYTE_W-1:0]           byte_lamps,
   input logic                        byte_par,
   input logic [ADDR_W-1:0]           addr_lamps,
   input logic [1:0]                  addr_par,
   input logic                        disp_valid,
   input logic                        eox_lamp
);
   localparam logic [SEL_W-1:0] STORE_CODE = SEL_W'(NREG);

   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   logic quiet, sel_ij, sel_uv;
   assign quiet  = !clk_run && !allow_wr;
   assign sel_ij = sel_code == SEL_W'(IDX_I) || sel_code == SEL_W'(IDX_J);
   assign sel_uv = sel_code == SEL_W'(IDX_U) || sel_code == SEL_W'(IDX_V);

   assert_byte_route_R1: assert property (@(posedge clk) disable iff (rst)
      armed && ($past(sel_code) < STORE_CODE) |-> byte_lamps == $past(regs[sel_code]));

   assert_pair_ij_R2: assert property (@(posedge clk) disable iff (rst)
      armed && $past(sel_ij && quiet) |->
         addr_lamps == $past({regs[IDX_I], regs[IDX_J]}) && disp_valid);

   assert_pair_uv_R3: assert property (@(posedge clk) disable iff (rst)
      armed && $past(sel_uv && quiet) |->
         addr_lamps == $past({regs[IDX_U], regs[IDX_V]}) && disp_valid);

   assert_interlock_R4: assert property (@(posedge clk) disable iff (rst)
      armed && $past((sel_ij || sel_uv) && !quiet) |-> addr_lamps == '0 && !disp_valid);

   assert_unused_blank_R6: assert property (@(posedge clk) disable iff (rst)
      armed && ($past(sel_code) > STORE_CODE) |->
         byte_lamps == '0 && addr_lamps == '0 && !byte_par && addr_par == 2'b00 && !disp_valid);

   assert_byte_parity_R7: assert property (@(posedge clk) disable iff (rst)
      armed && byte_par |-> ^{byte_lamps, byte_par});

   assert_eox_set_R8: assert property (@(posedge clk) disable iff (rst)
      armed && $past(uinst_step && uinst_boi) |-> eox_lamp);

   assert_eox_hold_R9: assert property (@(posedge clk) disable iff (rst)
      armed && $past(!uinst_step) |-> eox_lamp == $past(eox_lamp));
endmodule

bind console_lamp_select csl_checker #(
   .SEL_W(SEL_W), .BYTE_W(BYTE_W), .NREG(NREG),
   .IDX_I(IDX_I), .IDX_J(IDX_J), .IDX_U(IDX_U), .IDX_V(IDX_V)
) u_chk (.*);

// File: tb/console_lamp_select_test.sv
module console_lamp_select_test;
   localparam int CLK_PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst;
   logic [3:0]       sel_code;
   logic [11:0][7:0] regs;
   logic [7:0]       stor_data;
   logic [15:0]      stor_addr;
   logic             clk_run, allow_wr, uinst_step, uinst_boi;
   logic [7:0]       byte_lamps;
   logic             byte_par;
   logic [15:0]      addr_lamps;
   logic [1:0]       addr_par;
   logic             disp_valid, eox_lamp;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   console_lamp_select uut (
      .clk(clk), .rst(rst), .sel_code(sel_code), .regs(regs),
      .stor_data(stor_data), .stor_addr(stor_addr),
      .clk_run(clk_run), .allow_wr(allow_wr),
      .uinst_step(uinst_step), .uinst_boi(uinst_boi),
      .byte_lamps(byte_lamps), .byte_par(byte_par),
      .addr_lamps(addr_lamps), .addr_par(addr_par),
      .disp_valid(disp_valid), .eox_lamp(eox_lamp)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step_cycle();
      @(negedge clk);
   endtask

   task automatic load_pattern(input int pat);
      for (int k = 0; k < 12; k++) begin
         case (pat)
            0:       regs[k] = 8'h00;
            1:       regs[k] = 8'((k * 37 + 5) & 8'hff);
            default: regs[k] = 8'hff ^ 8'(k * 17);
         endcase
      end
      stor_data = (pat == 0) ? 8'h00 : 8'(8'h5a + pat);
      stor_addr = (pat == 0) ? 16'h0000 : 16'(16'hc3a1 ^ (pat * 16'h0101));
   endtask

   task automatic sweep_one(input int s, input bit run, input bit wr);
      logic [7:0]  eb;
      logic [15:0] ea;
      logic        bon, aon, ev, quiet;
      string       tag;
      quiet = !run && !wr;
      eb = 8'h00; ea = 16'h0000; bon = 0; aon = 0; ev = 0;
      if (s < 12) begin
         eb = regs[s]; bon = 1;
         if (s == 8 || s == 9) begin
            tag = quiet ? "R2" : "R4";
            if (quiet) begin ea = {regs[8], regs[9]}; aon = 1; ev = 1; end
         end else if (s == 10 || s == 11) begin
            tag = quiet ? "R3" : "R4";
            if (quiet) begin ea = {regs[10], regs[11]}; aon = 1; ev = 1; end
         end else begin
            tag = "R1"; ev = 1;
         end
      end else if (s == 12) begin
         tag = "R5";
         if (quiet) begin eb = stor_data; ea = stor_addr; bon = 1; aon = 1; ev = 1; end
      end else begin
         tag = "R6";
      end
      sel_code = 4'(s); clk_run = run; allow_wr = wr;
      step_cycle();
      check(tag, "byte_lamps", 32'(byte_lamps), 32'(eb));
      check(tag, "addr_lamps", 32'(addr_lamps), 32'(ea));
      check(tag, "disp_valid", 32'(disp_valid), 32'(ev));
      check("R7", "byte_par", 32'(byte_par), 32'(bon & ~(^eb)));
      check("R7", "addr_par", 32'(addr_par),
            32'({aon & ~(^ea[15:8]), aon & ~(^ea[7:0])}));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; sel_code = 4'd3; clk_run = 1'b1; allow_wr = 1'b1;
      uinst_step = 1'b1; uinst_boi = 1'b1;
      load_pattern(1);
      step_cycle(); step_cycle();
      // R10: reset state at the ports
      check("R10", "byte_lamps", 32'(byte_lamps), 0);
      check("R10", "addr_lamps", 32'(addr_lamps), 0);
      check("R10", "disp_valid", 32'(disp_valid), 0);
      check("R10", "eox_lamp", 32'(eox_lamp), 0);
      check("R10", "parity", 32'({byte_par, addr_par}), 0);
      rst = 1'b0; uinst_step = 1'b0; uinst_boi = 1'b0;

      for (int pat = 0; pat < 3; pat++) begin
         load_pattern(pat);
         for (int cond = 0; cond < 4; cond++)
            for (int s = 0; s < 16; s++)
               sweep_one(s, cond[1], cond[0]);
      end

      // End-of-execution latch
      uinst_step = 1'b1; uinst_boi = 1'b1; step_cycle();
      check("R8", "eox set", 32'(eox_lamp), 1);
      uinst_step = 1'b0; uinst_boi = 1'b0;
      for (int k = 0; k < 4; k++) begin
         step_cycle();
         check("R9", "eox hold set", 32'(eox_lamp), 1);
      end
      uinst_step = 1'b1; uinst_boi = 1'b0; step_cycle();
      check("R8", "eox clear", 32'(eox_lamp), 0);
      uinst_step = 1'b0; uinst_boi = 1'b1; step_cycle();
      check("R8", "boi without step", 32'(eox_lamp), 0);
      step_cycle();
      check("R9", "eox hold clear", 32'(eox_lamp), 0);
      uinst_step = 1'b1; uinst_boi = 1'b1; step_cycle();
      check("R8", "eox set again", 32'(eox_lamp), 1);
      uinst_step = 1'b1; uinst_boi = 1'b1; step_cycle();
      check("R8", "eox consecutive boi", 32'(eox_lamp), 1);

      // R10: reset from a populated state
      sel_code = 4'd8; clk_run = 1'b0; allow_wr = 1'b0; load_pattern(1);
      uinst_step = 1'b0; step_cycle();
      check("R2", "pre-reset valid", 32'(disp_valid), 1);
      rst = 1'b1; step_cycle();
      check("R10", "byte_lamps", 32'(byte_lamps), 0);
      check("R10", "addr_lamps", 32'(addr_lamps), 0);
      check("R10", "disp_valid", 32'(disp_valid), 0);
      check("R10", "eox_lamp", 32'(eox_lamp), 0);
      rst = 1'b0; step_cycle();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule